// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block models a synchronous SRAM with a pipelined read path and a built-in two-bit burst sequencer, backed by a small parameterised storage array. Every control and data input is captured on the rising clock edge. An access is opened by one of two address strobes. One strobe is meant for a processor and always starts a read. The other is meant for a system controller and can start either a read or a write. After the strobe, the low two address bits are generated internally for up to four beats. The advance input steps them, in linear or interleaved order.

Writes are byte-lane masked. A lane-write enable qualifies four per-lane enables, and a global write forces every lane. Read data passes through an array register and an output register. The first word of a burst therefore appears two edges after its address is captured, and each following word follows one cycle apart. The output is gated asynchronously by an output enable and a sleep input. When the output is not driven, it reads as zero and its drive flag is low.

Top module: `psram_burst`

## Requirements
- R1: While reset is active, and after it is released until the first access reaches the output, `dout_oe` is 0 and `dout` is all zero.
- R2: A new address and chip-select state are captured only at an edge where `strb_cpu_n` is low together with `cs_a_n` low, or where `strb_ctl_n` is low. When `cs_a_n` is high, `strb_cpu_n` is ignored, and the address and select state in use are kept.
- R3: The 2-bit beat counter is cleared on every address capture. It increments only at an edge where no capture happens and `adv_n` is low. At an edge with no capture and `adv_n` high, the same address is accessed again.
- R4: With `burst_ilv` = 0, beat n accesses low bits (start + n) mod 4. The order wraps after four beats, and address bits above bit 1 keep their captured value.
- R5: With `burst_ilv` = 1, beat n accesses low bits start XOR n. The order wraps after four beats, and address bits above bit 1 keep their captured value.
- R6: For a selected read at edge k, `dout` carries that word, with `dout_oe` = 1, after edge k+2 until edge k+3. Consecutive beats therefore give one word per cycle after a three-cycle first access.
- R7: At an edge with `all_wr_n` = 1 and `lane_wr_n` = 0, lane i (bits 8i+7..8i) is written from `din` when `lane_en_n[i]` = 0, and the other lanes keep their contents. With `lane_wr_n` = 1 and `all_wr_n` = 1, nothing is written and the edge is a read. A write edge never drives the output.
- R8: At an edge with `all_wr_n` = 0, all four lanes are written, whatever `lane_en_n` and `lane_wr_n` hold.
- R9: An edge that captures through `strb_cpu_n` is a read. Write controls at that edge are ignored. They take effect at later edges of the same burst.
- R10: The chip is selected only if `cs_a_n` = 0, `cs_b` = 1 and `cs_c_n` = 0 at the capture edge. Until the next capture, a deselected state writes nothing, and its slots leave `dout_oe` = 0 two edges later.
- R11: When `oe_n` = 1 or `sleep` = 1, `dout_oe` is 0 and `dout` is zero at once, without a clock edge. The output returns as soon as both are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| addr | input | AW (6) | Word address captured by a strobe |
| din | input | DW (32) | Write data |
| cs_a_n | input | 1 | Select, active low; also gates the processor strobe |
| cs_b | input | 1 | Select, active high |
| cs_c_n | input | 1 | Select, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low, read only, has priority |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_en_n | input | NB (4) | Per-lane write enables, active low |
| lane_wr_n | input | 1 | Qualifier for the per-lane enables, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep, active high, asynchronous output gate |
| dout | output | DW (32) | Read data, zero when not driven |
| dout_oe | output | 1 | High while `dout` carries valid read data |

## Verification
The array is first filled with per-address distinct words, so every beat identifies the address it came from. Bursts start from low bits 2 and 3 in both orders: a start of 3 gives 3,2,1,0 interleaved against 3,0,1,2 linear, and a fifth advance shows the wrap. A burst with a held middle beat separates advance-gated counting from free running. Single-lane, two-lane, qualifier-off and global writes each carry different data and are read back, so a wrong mask, priority or lane position changes a visible byte. Processor-strobe captures with write controls active, strobes with `cs_a_n` high, deselected captures with writes, and `oe_n`/`sleep` pulses during reads show whether control is ignored, kept or gated.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;

  // Order of beats inside a four-word group.
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

  localparam int BEAT_W = 2;

  // Low address bits for beat n given the captured start bits.
  function automatic logic [BEAT_W-1:0] beat_bits(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input burst_order_e      order
  );
    logic [BEAT_W-1:0] res;
    if (order == ORDER_XOR) res = start ^ beat;
    else                    res = start + beat;
    return res;
  endfunction

endpackage

// File: rtl/psram_rst_sync.sv
`timescale 1ns/1ps
module psram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/psram_ctl.sv
`timescale 1ns/1ps
module psram_ctl
  import psram_pkg::*;
#(
  parameter  int AW     = 6,
  parameter  int DW     = 32,
  parameter  int LANE_W = 8,
  localparam int NB     = DW / LANE_W
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          cs_a_n,
  input  logic          cs_b,
  input  logic          cs_c_n,
  input  logic          strb_cpu_n,
  input  logic          strb_ctl_n,
  input  logic          adv_n,
  input  logic [NB-1:0] lane_en_n,
  input  logic          lane_wr_n,
  input  logic          all_wr_n,
  input  logic          burst_ilv,
  output logic [AW-1:0] acc_addr,
  output logic          acc_sel,
  output logic          acc_wr,
  output logic [NB-1:0] acc_mask,
  output logic [DW-1:0] acc_wdata
);
  // Burst state
  logic [AW-1:0]     base_q, base_d;
  logic [BEAT_W-1:0] cnt_q, cnt_d;
  logic              sel_q, sel_d;

  // Decoded edge
  logic              ld_cpu, ld_any, sel_hit;
  logic [NB-1:0]     lanes_sel, mask_d;
  logic              wr_d;
  logic [AW-1:0]     addr_d;
  burst_order_e      order;

  assign order = burst_order_e'(burst_ilv);

  always_comb begin
    ld_cpu  = !strb_cpu_n && !cs_a_n;
    ld_any  = ld_cpu || !strb_ctl_n;
    sel_hit = !cs_a_n && cs_b && !cs_c_n;

    if (ld_any) begin
      base_d = addr;
      cnt_d  = '0;
      sel_d  = sel_hit;
    end else begin
      base_d = base_q;
      sel_d  = sel_q;
      cnt_d  = adv_n ? cnt_q : cnt_q + 1'b1;
    end

    addr_d = {base_d[AW-1:BEAT_W], beat_bits(base_d[BEAT_W-1:0], cnt_d, order)};

    if (!all_wr_n)       lanes_sel = '1;
    else if (!lane_wr_n) lanes_sel = ~lane_en_n;
    else                 lanes_sel = '0;

    wr_d   = sel_d && !ld_cpu && (|lanes_sel);
    mask_d = wr_d ? lanes_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      cnt_q    <= '0;
      sel_q    <= 1'b0;
      acc_addr <= '0;
      acc_sel  <= 1'b0;
      acc_wr   <= 1'b0;
      acc_mask <= '0;
    end else begin
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      sel_q    <= sel_d;
      acc_addr <= addr_d;
      acc_sel  <= sel_d;
      acc_wr   <= wr_d;
      acc_mask <= mask_d;
    end
  end

  // Write data only loads on a write edge.
  always_ff @(posedge clk) begin
    if (wr_d) acc_wdata <= din;
  end

  // R3: no capture and no advance keeps the beat count
  p_hold_cnt_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ld_any && adv_n) |=> $stable(cnt_q));

  // R4/R5: upper address bits never move inside a burst
  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !ld_any |=> $stable(acc_addr[AW-1:BEAT_W]));

  // R9: processor strobe capture is a read
  p_cpu_read_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    ld_cpu |=> (!acc_wr && acc_mask == '0));

  // R8: global write on a selected continuation edge writes every lane
  p_gw_mask_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!all_wr_n && !ld_any && sel_q) |=> (acc_wr && acc_mask == '1));
endmodule

// File: rtl/psram_array.sv
`timescale 1ns/1ps
module psram_array #(
  parameter  int AW     = 6,
  parameter  int DW     = 32,
  parameter  int LANE_W = 8,
  localparam int NB     = DW / LANE_W,
  localparam int DEPTH  = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_sel,
  input  logic          acc_wr,
  input  logic [NB-1:0] acc_mask,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld
);
  logic          rd_en;
  logic [DW-1:0] rd_word;

  assign rd_en = acc_sel & ~acc_wr;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (acc_wr && acc_mask[g]) lane_mem[acc_addr] <= acc_wdata[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = lane_mem[acc_addr];
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= rd_word;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rd_vld <= 1'b0;
    else         rd_vld <= rd_en;
  end

  // R10: a deselected slot never reaches the array as a write
  p_desel_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !acc_sel |-> (!acc_wr && acc_mask == '0));
endmodule

// File: rtl/psram_out.sv
`timescale 1ns/1ps
module psram_out #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_vld,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  logic [DW-1:0] out_data;
  logic          out_vld;

  always_ff @(posedge clk) begin
    if (rd_vld) out_data <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) out_vld <= 1'b0;
    else         out_vld <= rd_vld;
  end

  // Asynchronous gating of the registered word.
  always_comb begin
    dout_oe = out_vld & ~oe_n & ~sleep;
    dout    = dout_oe ? out_data : '0;
  end

  // R11: gated output shows nothing while disabled
  p_float_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (oe_n || sleep) |-> (!dout_oe && dout == '0));
endmodule

// File: rtl/psram_burst.sv
`timescale 1ns/1ps
module psram_burst #(
  parameter  int AW     = 6,
  parameter  int DW     = 32,
  parameter  int LANE_W = 8,
  localparam int NB     = DW / LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          cs_a_n,
  input  logic          cs_b,
  input  logic          cs_c_n,
  input  logic          strb_cpu_n,
  input  logic          strb_ctl_n,
  input  logic          adv_n,
  input  logic [NB-1:0] lane_en_n,
  input  logic          lane_wr_n,
  input  logic          all_wr_n,
  input  logic          burst_ilv,
  input  logic          oe_n,
  input  logic          sleep,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  logic          rst_s;
  logic [AW-1:0] acc_addr;
  logic          acc_sel, acc_wr;
  logic [NB-1:0] acc_mask;
  logic [DW-1:0] acc_wdata;
  logic [DW-1:0] rd_data;
  logic          rd_vld;

  psram_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s)
  );

  psram_ctl #(.AW(AW), .DW(DW), .LANE_W(LANE_W)) u_ctl (
    .clk        (clk),
    .rst_ni     (rst_s),
    .addr       (addr),
    .din        (din),
    .cs_a_n     (cs_a_n),
    .cs_b       (cs_b),
    .cs_c_n     (cs_c_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .lane_en_n  (lane_en_n),
    .lane_wr_n  (lane_wr_n),
    .all_wr_n   (all_wr_n),
    .burst_ilv  (burst_ilv),
    .acc_addr   (acc_addr),
    .acc_sel    (acc_sel),
    .acc_wr     (acc_wr),
    .acc_mask   (acc_mask),
    .acc_wdata  (acc_wdata)
  );

  psram_array #(.AW(AW), .DW(DW), .LANE_W(LANE_W)) u_array (
    .clk       (clk),
    .rst_ni    (rst_s),
    .acc_addr  (acc_addr),
    .acc_sel   (acc_sel),
    .acc_wr    (acc_wr),
    .acc_mask  (acc_mask),
    .acc_wdata (acc_wdata),
    .rd_data   (rd_data),
    .rd_vld    (rd_vld)
  );

  psram_out #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_ni  (rst_s),
    .rd_data (rd_data),
    .rd_vld  (rd_vld),
    .oe_n    (oe_n),
    .sleep   (sleep),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

  // R6: a driven output comes from a selected read slot two edges back
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_s)
    dout_oe |-> ($past(acc_sel, 2) && !$past(acc_wr, 2)));
endmodule

// File: tb/psram_burst_bench.sv
`timescale 1ns/1ps
module psram_burst_bench;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic          cs_a_n, cs_b, cs_c_n;
  logic          strb_cpu_n, strb_ctl_n, adv_n;
  logic [NB-1:0] lane_en_n;
  logic          lane_wr_n, all_wr_n, burst_ilv, oe_n, sleep;
  logic [DW-1:0] dout;
  logic          dout_oe;

  always #2.5 clk = ~clk;

  psram_burst u_psram_burst (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .lane_en_n(lane_en_n), .lane_wr_n(lane_wr_n), .all_wr_n(all_wr_n),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .sleep(sleep),
    .dout(dout), .dout_oe(dout_oe)
  );

  typedef struct {
    int          due;
    logic        vld;
    logic [31:0] data;
    string       req;
  } item_t;

  item_t       exp_q[$];
  int          checks = 0;
  int          fails  = 0;
  int          edge_n = 0;
  bit          done   = 0;
  bit          mon_on = 0;

  // Reference state
  logic [31:0] ref_mem [64];
  logic [5:0]  m_base = '0;
  logic [1:0]  m_cnt  = '0;
  logic        m_sel  = 1'b0;

  always @(posedge clk) edge_n <= edge_n + 1;

  function automatic logic [31:0] pat(input int a);
    return 32'hC0DE_0000 + a * 32'h0001_0101;
  endfunction

  task automatic check(input string req, input logic ok, input logic [31:0] act,
                       input logic [31:0] exp_v, input logic act_oe, input logic exp_oe);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at edge %0d: dout_oe=%b dout=%h expected dout_oe=%b dout=%h",
               req, edge_n, act_oe, act, exp_oe, exp_v);
    end
  endtask

  task automatic idle_inputs();
    addr = '0; din = '0;
    cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
    strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; adv_n = 1'b1;
    lane_en_n = '1; lane_wr_n = 1'b1; all_wr_n = 1'b1;
    oe_n = 1'b0; sleep = 1'b0;
  endtask

  // Reference model of one edge; pushes the expected output slot.
  task automatic tick(input string req);
    logic       ld_cpu, ld, wr;
    logic [5:0] a;
    logic [3:0] lanes;
    item_t      it;
    ld_cpu = !strb_cpu_n && !cs_a_n;
    ld     = ld_cpu || !strb_ctl_n;
    if (ld) begin
      m_base = addr; m_cnt = 2'd0; m_sel = !cs_a_n && cs_b && !cs_c_n;
    end else if (!adv_n) begin
      m_cnt = m_cnt + 2'd1;
    end
    a = {m_base[5:2], burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
    if (!all_wr_n)      lanes = 4'hF;
    else if (!lane_wr_n) lanes = ~lane_en_n;
    else                lanes = 4'h0;
    wr = m_sel && !ld_cpu && (lanes != 4'h0);
    if (wr) begin
      for (int i = 0; i < 4; i++)
        if (lanes[i]) ref_mem[a][i*8 +: 8] = din[i*8 +: 8];
    end
    it.due  = edge_n + 3;
    it.vld  = m_sel && !wr;
    it.data = ref_mem[a];
    it.req  = req;
    exp_q.push_back(it);
    mon_on = 1;
    @(negedge clk);
  endtask

  // Monitor: compare the slot due now, using the live gate inputs.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_on && exp_q.size() > 0 && exp_q[0].due <= edge_n) begin
        item_t it;
        logic  e_oe;
        it   = exp_q.pop_front();
        e_oe = it.vld && !oe_n && !sleep;
        if (e_oe)
          check(it.req, (dout_oe === 1'b1) && (dout === it.data), dout, it.data, dout_oe, 1'b1);
        else
          check(it.req, (dout_oe === 1'b0) && (dout === 32'h0), dout, 32'h0, dout_oe, 1'b0);
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    idle_inputs();
    burst_ilv = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", (dout_oe === 1'b0) && (dout === 32'h0), dout, 32'h0, dout_oe, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", (dout_oe === 1'b0) && (dout === 32'h0), dout, 32'h0, dout_oe, 1'b0);

    // Fill with global writes (R8)
    for (int a = 0; a < 64; a++) begin
      idle_inputs(); strb_ctl_n = 1'b0; addr = 6'(a); all_wr_n = 1'b0; din = pat(a);
      tick("R8");
    end

    // Linear burst from start 2: 6,7,4,5 then wrap to 6 (R4, R6)
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd6; tick("R6");
    for (int i = 0; i < 4; i++) begin idle_inputs(); adv_n = 1'b0; tick("R4"); end
    idle_inputs(); tick("R3");

    // Interleaved burst from start 3: 11,10,9,8 then wrap to 11 (R5)
    burst_ilv = 1'b1;
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd11; tick("R5");
    for (int i = 0; i < 4; i++) begin idle_inputs(); adv_n = 1'b0; tick("R5"); end
    burst_ilv = 1'b0;
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd11; tick("R4");
    for (int i = 0; i < 3; i++) begin idle_inputs(); adv_n = 1'b0; tick("R4"); end

    // Advance gating: 20,21,21,22 (R3)
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd20; tick("R3");
    idle_inputs(); adv_n = 1'b0; tick("R3");
    idle_inputs(); tick("R3");
    idle_inputs(); adv_n = 1'b0; tick("R3");

    // Processor strobe ignores write controls (R9)
    idle_inputs(); strb_cpu_n = 1'b0; addr = 6'd30; all_wr_n = 1'b0; lane_wr_n = 1'b0;
    lane_en_n = 4'h0; din = 32'hDEAD_BEEF; tick("R9");
    // Processor strobe with cs_a_n high is ignored: address 30 kept (R2)
    idle_inputs(); strb_cpu_n = 1'b0; cs_a_n = 1'b1; addr = 6'd40; tick("R2");
    idle_inputs(); tick("R2");
    // Processor strobe read then write on the next edge of the burst (R9)
    idle_inputs(); strb_cpu_n = 1'b0; addr = 6'd33; tick("R9");
    idle_inputs(); all_wr_n = 1'b0; din = 32'h1357_9BDF; tick("R9");
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd33; tick("R9");
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd30; tick("R9");

    // Deselected captures write nothing and do not drive (R10)
    idle_inputs(); strb_ctl_n = 1'b0; cs_b = 1'b0; addr = 6'd12; all_wr_n = 1'b0;
    din = 32'hBAD0_0001; tick("R10");
    idle_inputs(); adv_n = 1'b0; all_wr_n = 1'b0; din = 32'hBAD0_0002; tick("R10");
    idle_inputs(); strb_ctl_n = 1'b0; cs_c_n = 1'b1; addr = 6'd13; all_wr_n = 1'b0;
    din = 32'hBAD0_0003; tick("R10");
    idle_inputs(); strb_cpu_n = 1'b0; cs_a_n = 1'b1; strb_ctl_n = 1'b0; addr = 6'd14; tick("R10");
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd12; tick("R10");
    idle_inputs(); adv_n = 1'b0; tick("R10");

    // Lane writes (R7)
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd13; lane_wr_n = 1'b0; lane_en_n = 4'b1110;
    din = 32'h1122_3344; tick("R7");
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd14; lane_wr_n = 1'b0; lane_en_n = 4'b0011;
    din = 32'hAABB_CCDD; tick("R7");
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd15; lane_wr_n = 1'b1; lane_en_n = 4'b0000;
    din = 32'h0F0F_0F0F; tick("R7");
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd13; tick("R7");
    idle_inputs(); adv_n = 1'b0; tick("R7");
    idle_inputs(); adv_n = 1'b0; tick("R7");

    // Global write overrides lane enables (R8)
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd16; all_wr_n = 1'b0; lane_en_n = 4'hF;
    lane_wr_n = 1'b1; din = 32'h7654_3210; tick("R8");
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd16; tick("R8");

    // Asynchronous output gating during a burst (R11)
    idle_inputs(); strb_ctl_n = 1'b0; addr = 6'd24; tick("R11");
    idle_inputs(); adv_n = 1'b0; tick("R11");
    idle_inputs(); adv_n = 1'b0; oe_n = 1'b1; tick("R11");
    idle_inputs(); adv_n = 1'b0; sleep = 1'b1; tick("R11");
    idle_inputs(); tick("R11");
    idle_inputs(); oe_n = 1'b1; sleep = 1'b1; tick("R11");
    idle_inputs(); tick("R11");

    // Drain with a deselected capture
    idle_inputs(); strb_ctl_n = 1'b0; cs_b = 1'b0; tick("R10");
    for (int i = 0; i < 3; i++) begin idle_inputs(); tick("R10"); end
    repeat (2) @(negedge clk);
    done = 1;
    finish_up();
  end
endmodule